// File: doc/BRIEF.md
# Shared Timer Prescaler with External Clock Input

This block turns the system clock into count-enable pulses for two timer/counters. A single free-running counter supplies four divided taps, at 1/8, 1/64, 1/256 and 1/1024 of the system clock. Both timers draw on these same taps. Each timer also has an external clock pin. That pin is synchronized to the system clock and then edge-detected. The resulting edge pulse goes around the prescaler and is never divided.

Each timer has a 3-bit select. It chooses what drives that timer's enable: nothing, every system clock, one of the four taps, or the falling or rising edge of the external pin. The output is a single-cycle pulse per timer, and the timer counts on every cycle in which its pulse is high.

A one-bit control register restarts the shared counter. A write with data one restarts it, and the bit then clears itself. A write with data zero does nothing. The bit always reads back as zero. A restart moves the tap phase of both timers at the same time. It does not affect the external-pin path.

No data streams pass through the block. All pins are plain control and status signals, with no handshake.

Top module: `shared_tmr_prescaler`

## Requirements
- R1: A timer whose select is 0 never asserts its count enable, whatever its external pin does.
- R2: A timer whose select is 1 asserts its count enable in every cycle after reset.
- R3: Select codes 2, 3, 4 and 5 give divide ratios of 8, 64, 256 and 1024.
  - The counter starts at zero after reset release and advances by one on each clock.
  - The enable is a one-cycle pulse, high in the cycle where the counter's low log2(ratio) bits are all ones.
  - The first pulse therefore comes in the ratio-th cycle after the counter starts.
- R4: On the clock edge that ends a cycle with `psr_wr_i`=1 and `psr_wdata_i`=1, the shared counter returns to zero. The taps of both timers then restart their full period.
- R5: A write with `psr_wdata_i`=0 has no effect on the counter or on any enable.
- R6: `psr_rdata_o` is zero at all times, including during reset and right after a restart write.
- R7: With select 7, each rising edge on the timer's external pin gives exactly one enable pulse.
  - A pin change applied before clock edge n shows as a pulse in the cycle after edge n+1.
- R8: With select 6, each falling edge on the external pin gives exactly one enable pulse, with the same two-edge latency as R7.
- R9: External-edge pulses have the same timing whether or not a prescaler restart is written in between.
- R10: While reset is held, a timer with select 2 to 7 has its count enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psr_wr_i | input | 1 | Write strobe for the prescaler restart bit |
| psr_wdata_i | input | 1 | Write data for the restart bit (1 restarts) |
| psr_rdata_o | output | 1 | Read value of the restart bit (always 0) |
| sel_i | input | N_TMR x 3 | Per-timer source select (0 off, 1 sysclk, 2-5 taps, 6 fall, 7 rise) |
| ext_pin_i | input | N_TMR | Per-timer external clock pins, asynchronous |
| cnt_en_o | output | N_TMR | Per-timer single-cycle count enable |

## Verification
The bench goes after the first-pulse phase of every tap, both after reset and after a restart write in mid-period.
- A counter that is off by one would place each pulse one cycle early or late.
- A restart that reached only one timer would leave the other tap's phase unchanged.

A zero write is issued in mid-period; a design that treated any write as a restart would shift every later tap pulse. External pins are toggled in both edge modes with a restart in between. A wrong synchronizer depth would move pulses by a cycle, and a missing edge compare would hold the enable high for as long as the pin stays high.

// File: rtl/tmr_pre_pkg.sv
package tmr_pre_pkg;

  localparam int SEL_W  = 3;
  localparam int N_TAPS = 4;
  localparam int CNT_W  = 10;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_SYS      = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_sel_e;

  // log2 of the divide ratio for tap t
  function automatic int tap_shift(input int t);
    case (t)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/prescale_core.sv
module prescale_core
  import tmr_pre_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  output logic [N_TAPS-1:0] tap_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    localparam int SH = tap_shift(t);
    assign tap_o[t] = &cnt_q[SH-1:0];
  end

endmodule

// File: rtl/ext_edge_det.sv
module ext_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  last_q;

endmodule

// File: rtl/src_select.sv
module src_select
  import tmr_pre_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              en_o
);

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_OFF:      en_o = 1'b0;
      SRC_SYS:      en_o = rst_n;
      SRC_DIV8:     en_o = tap_i[0];
      SRC_DIV64:    en_o = tap_i[1];
      SRC_DIV256:   en_o = tap_i[2];
      SRC_DIV1024:  en_o = tap_i[3];
      SRC_EXT_FALL: en_o = fall_i;
      SRC_EXT_RISE: en_o = rise_i;
      default:      en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/shared_tmr_prescaler.sv
module shared_tmr_prescaler
  import tmr_pre_pkg::*;
#(
  parameter int N_TMR = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        psr_wr_i,
  input  logic                        psr_wdata_i,
  output logic                        psr_rdata_o,
  input  logic [N_TMR-1:0][SEL_W-1:0] sel_i,
  input  logic [N_TMR-1:0]            ext_pin_i,
  output logic [N_TMR-1:0]            cnt_en_o
);

  logic              restart_w;
  logic [N_TAPS-1:0] tap_w;

  // the restart bit acts on the write and holds no state
  assign restart_w   = psr_wr_i & psr_wdata_i;
  assign psr_rdata_o = 1'b0;

  prescale_core #(.CW(CNT_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_w),
    .tap_o     (tap_w)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic rise_w, fall_w;

    ext_edge_det #(.SYNC_STAGES(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_pin_i[i]),
      .rise_o (rise_w),
      .fall_o (fall_w)
    );

    src_select u_sel (
      .sel_i  (sel_i[i]),
      .rst_n  (rst_n),
      .tap_i  (tap_w),
      .rise_i (rise_w),
      .fall_i (fall_w),
      .en_o   (cnt_en_o[i])
    );
  end

endmodule

// File: rtl/tmr_pre_chk.sv
module tmr_pre_chk
  import tmr_pre_pkg::*;
#(
  parameter int N_TMR = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        psr_wr_i,
  input logic                        psr_wdata_i,
  input logic [N_TMR-1:0][SEL_W-1:0] sel_i,
  input logic [N_TMR-1:0]            cnt_en_o,
  input logic [N_TAPS-1:0]           tap_w
);

  // R4
  restart_clears_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_i && psr_wdata_i) |=> (tap_w == '0));

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tapchk
    // R3
    tap_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_w[t] |=> !tap_w[t]);
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_tchk
    // R1
    off_never_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i[i] == SRC_OFF) |-> !cnt_en_o[i]);
    // R2
    sys_always_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i[i] == SRC_SYS) |-> cnt_en_o[i]);
    // R7
    rise_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i[i] == SRC_EXT_RISE && cnt_en_o[i]) |=>
        !(sel_i[i] == SRC_EXT_RISE && cnt_en_o[i]));
    // R8
    fall_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i[i] == SRC_EXT_FALL && cnt_en_o[i]) |=>
        !(sel_i[i] == SRC_EXT_FALL && cnt_en_o[i]));
  end

endmodule

bind shared_tmr_prescaler tmr_pre_chk #(.N_TMR(N_TMR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .psr_wr_i    (psr_wr_i),
  .psr_wdata_i (psr_wdata_i),
  .sel_i       (sel_i),
  .cnt_en_o    (cnt_en_o),
  .tap_w       (tap_w)
);

// File: tb/tb_shared_tmr_prescaler.sv
`timescale 1ns/1ps
module tb_shared_tmr_prescaler;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            psr_wr = 1'b0;
  logic            psr_wdata = 1'b0;
  logic            psr_rdata;
  logic [1:0][2:0] sel = '0;
  logic [1:0]      pin = '0;
  logic [1:0]      en;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int kmod    = 0;
  bit mon_on  = 0;
  bit done    = 0;
  string tag  = "";
  int exp_q0[$];
  int exp_q1[$];

  always #4 clk = ~clk;

  shared_tmr_prescaler #(.N_TMR(2)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .psr_wr_i    (psr_wr),
    .psr_wdata_i (psr_wdata),
    .psr_rdata_o (psr_rdata),
    .sel_i       (sel),
    .ext_pin_i   (pin),
    .cnt_en_o    (en)
  );

  // reference model of the shared counter, built from R3/R4/R5
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || (psr_wr && psr_wdata)) kmod <= 0;
    else                                 kmod <= kmod + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: compares against the model and the scoreboard queues
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      for (int t = 0; t < 2; t++) begin
        int    e;
        int    sh;
        string r;
        e = 0;
        r = "";
        case (sel[t])
          3'd0: begin e = 0; r = "R1"; end
          3'd1: begin e = 1; r = "R2"; end
          3'd6, 3'd7: begin
            r = (sel[t] == 3'd7) ? "R7" : "R8";
            if (t == 0) begin
              if (exp_q0.size() > 0 && exp_q0[0] == cyc) begin e = 1; void'(exp_q0.pop_front()); end
            end else begin
              if (exp_q1.size() > 0 && exp_q1[0] == cyc) begin e = 1; void'(exp_q1.pop_front()); end
            end
          end
          default: begin
            sh = (sel[t] == 3'd2) ? 3 : (sel[t] == 3'd3) ? 6 : (sel[t] == 3'd4) ? 8 : 10;
            e  = ((kmod % (1 << sh)) == (1 << sh) - 1) ? 1 : 0;
            r  = "R3";
          end
        endcase
        if (tag != "") r = {r, "/", tag};
        chk(r, int'(en[t]), e);
      end
      chk("R6", int'(psr_rdata), 0);
    end
  end

  // driver: toggles a pin and queues the pulse the requirements predict
  task automatic toggle_pin(input int t);
    logic nv;
    @(negedge clk);
    nv = ~pin[t];
    pin[t] = nv;
    if ((nv && sel[t] == 3'd7) || (!nv && sel[t] == 3'd6)) begin
      if (t == 0) exp_q0.push_back(cyc + 2);
      else        exp_q1.push_back(cyc + 2);
    end
  endtask

  task automatic psr_write(input logic d);
    @(negedge clk);
    psr_wr = 1'b1;
    psr_wdata = d;
    @(negedge clk);
    psr_wr = 1'b0;
    psr_wdata = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: enables stay low under reset
    sel[0] = 3'd2; sel[1] = 3'd7;
    repeat (5) @(negedge clk);
    #1;
    chk("R10", int'(en[0]), 0);
    chk("R10", int'(en[1]), 0);
    chk("R6", int'(psr_rdata), 0);
    sel[1] = 3'd3;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;

    // R3 first pulses after reset release
    idle(200);
    sel[0] = 3'd4; sel[1] = 3'd5;
    idle(2100);

    // R4 restart in mid-period affects both timers
    tag = "R4";
    idle(333);
    psr_write(1'b1);
    idle(1100);
    sel[0] = 3'd2; sel[1] = 3'd3;
    idle(37);
    psr_write(1'b1);
    idle(150);

    // R5 zero write has no effect
    tag = "R5";
    idle(13);
    psr_write(1'b0);
    idle(1100);
    tag = "";

    // R1 and R2 with pins toggling
    sel[0] = 3'd1; sel[1] = 3'd0;
    for (int n = 0; n < 10; n++) begin
      toggle_pin(0); toggle_pin(1); idle(3);
    end
    pin = '0;
    idle(5);

    // R7 rising on timer 0, R8 falling on timer 1
    sel[0] = 3'd7; sel[1] = 3'd6;
    idle(5);
    for (int n = 0; n < 12; n++) begin
      toggle_pin(0); idle(2);
      toggle_pin(1); idle(4);
    end
    // R9 restart interleaved with edges
    tag = "R9";
    for (int n = 0; n < 6; n++) begin
      toggle_pin(0);
      psr_write(1'b1);
      toggle_pin(1);
      idle(4);
    end
    idle(10);
    tag = "";
    chk("R7", exp_q0.size(), 0);
    chk("R8", exp_q1.size(), 0);
    mon_on = 0;
    finish_run();
  end

endmodule